// File: doc/BRIEF.md
# Two-Bit Burst Address Generator

This block sits in front of a synchronous memory array and supplies the address of each beat of a four-beat burst. A burst starts when either of two address strobes is high at a rising clock edge. One strobe comes from the processor side and the other from the memory-controller side. On that edge the block captures the external address and the order select. Each later edge with the advance input high moves the beat count on by one. Only the low two address bits change during a burst; the upper bits stay as captured.

The low bits follow one of two orders. In linear order they count upward from the start value and wrap modulo four. In interleaved order the start value is XORed with the beat count. A strobe may be given on every cycle, so a user that does not need bursts can present a fresh address each clock and pay no penalty. A flag marks the fourth beat of a burst.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `cur_addr` to zero, sets the beat count to zero and clears `last_beat`.
- R2: At a rising edge where `stb_cpu` or `stb_ctl` is high, the block captures `ext_addr` and restarts the beat count. After that edge, `cur_addr` equals the captured address and `last_beat` is low.
- R3: When both strobes are high together, the processor strobe wins and the result is a normal load. A strobe that comes with `adv` high still loads, and the advance has no effect.
- R4: At an edge where no strobe and no `adv` is high, `cur_addr` and `last_beat` do not change.
- R5: When the order captured at load is linear (`order_sel` = 1), the two low address bits equal (start + k) mod 4, where k is the number of advances since the load, taken mod 4.
- R6: When the order captured at load is interleaved (`order_sel` = 0, the default when the input is tied low), the two low address bits equal start XOR k.
- R7: Bits above bit 1 of `cur_addr` stay equal to the captured address for the whole burst.
- R8: `last_beat` is high exactly when k mod 4 equals 3.
- R9: The fourth advance after a load returns `cur_addr` to the start address, and further advances repeat the same sequence.
- R10: `order_sel` is sampled only at a load edge. Changing it in the middle of a burst does not alter the sequence.
- R11: Strobes on back-to-back cycles each load their own address, and no cycle is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr | input | ADDR_W | External start address |
| stb_cpu | input | 1 | Processor-side strobe; loads `ext_addr`; has priority |
| stb_ctl | input | 1 | Controller-side strobe; loads `ext_addr` |
| adv | input | 1 | Advances the beat count when no strobe is high |
| order_sel | input | 1 | Burst order: 1 = linear, 0 = interleaved |
| cur_addr | output | ADDR_W | Address of the current beat |
| last_beat | output | 1 | High on the fourth beat of a burst |

## Verification
The hardest situation to reach is a burst that has wrapped and is still advancing while the order select toggles on every edge. Reaching it needs long runs of advances with strobes withheld, and the sequence must still match the order captured at load. The sweep covers every start value, both orders and each strobe combination. In each burst it runs six advances, with idle gaps and a toggle of `order_sel` between them. Separate runs put a strobe together with `adv` high, and issue strobes on back-to-back cycles.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_ILV = 1'b0,
    ORD_LIN = 1'b1
  } order_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CPU  = 2'd1,
    SRC_CTL  = 2'd2
  } src_e;
endpackage

// File: rtl/burst_strobe_arb.sv
module burst_strobe_arb
  import burst_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic stb_cpu,
  input  logic stb_ctl,
  input  logic adv,
  output logic load,
  output logic step,
  output src_e src
);
  always_comb begin
    if (stb_cpu)      src = SRC_CPU;
    else if (stb_ctl) src = SRC_CTL;
    else              src = SRC_NONE;
  end

  assign load = (src != SRC_NONE);
  assign step = adv && !load;

  // R3: priority goes to the processor strobe whenever it is present
  assert_cpu_priority_R3: assert property (@(posedge clk) disable iff (rst)
    stb_cpu |-> (src == SRC_CPU));
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BURST_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               step,
  output logic [BURST_W-1:0] beat,
  output logic               last
);
  localparam logic [BURST_W-1:0] BEAT_MAX = {BURST_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || load) beat <= '0;
    else if (step)   beat <= beat + 1'b1;
  end

  assign last = (beat == BEAT_MAX);

  assert_beat_clear_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (beat == '0));
  assert_beat_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(beat));
  assert_beat_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (!load && step && last) |=> (beat == '0));
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
  import burst_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              order_in,
  output logic [ADDR_W-1:0] base,
  output order_e            order
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base  <= '0;
      order <= ORD_ILV;
    end else if (load) begin
      base  <= addr_in;
      order <= order_e'(order_in);
    end
  end

  // R10, R7: the captured start address and order change only on a load
  assert_base_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(base) && $stable(order)));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              stb_cpu,
  input  logic              stb_ctl,
  input  logic              adv,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              last_beat
);
  localparam int HI_W = ADDR_W - BURST_W;

  function automatic logic [BURST_W-1:0] lin_lo(input logic [BURST_W-1:0] s,
                                                input logic [BURST_W-1:0] k);
    return BURST_W'(s + k);
  endfunction

  function automatic logic [BURST_W-1:0] ilv_lo(input logic [BURST_W-1:0] s,
                                                input logic [BURST_W-1:0] k);
    return s ^ k;
  endfunction

  logic               load_ev;
  logic               step_ev;
  src_e               src;
  logic [BURST_W-1:0] beat;
  logic               beat_last;
  logic [ADDR_W-1:0]  base;
  order_e             order;
  logic [BURST_W-1:0] lo_bits;

  burst_strobe_arb u_arb (
    .clk(clk), .rst(rst), .stb_cpu(stb_cpu), .stb_ctl(stb_ctl), .adv(adv),
    .load(load_ev), .step(step_ev), .src(src)
  );

  burst_beat_ctr #(.BURST_W(BURST_W)) u_ctr (
    .clk(clk), .rst(rst), .load(load_ev), .step(step_ev),
    .beat(beat), .last(beat_last)
  );

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk(clk), .rst(rst), .load(load_ev), .addr_in(ext_addr),
    .order_in(order_sel), .base(base), .order(order)
  );

  always_comb begin
    if (order == ORD_LIN) lo_bits = lin_lo(base[BURST_W-1:0], beat);
    else                  lo_bits = ilv_lo(base[BURST_W-1:0], beat);
  end

  assign cur_addr  = {base[ADDR_W-1:BURST_W], lo_bits};
  assign last_beat = beat_last;

  assert_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (cur_addr == '0 && !last_beat));
  assert_load_addr_R2: assert property (@(posedge clk) disable iff (rst)
    (stb_cpu || stb_ctl) |=> (cur_addr == $past(ext_addr) && !last_beat));
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!stb_cpu && !stb_ctl && !adv) |=> ($stable(cur_addr) && $stable(last_beat)));
  assert_lin_step_R5: assert property (@(posedge clk) disable iff (rst)
    (!stb_cpu && !stb_ctl && adv && order == ORD_LIN)
      |=> (cur_addr[BURST_W-1:0] == BURST_W'($past(cur_addr[BURST_W-1:0]) + 1'b1)));
  assert_upper_fixed_R7: assert property (@(posedge clk) disable iff (rst)
    (!stb_cpu && !stb_ctl) |=> (cur_addr[ADDR_W-1:BURST_W] == $past(cur_addr[ADDR_W-1:BURST_W])));
  assert_hi_width_R7: assert final (HI_W > 0);
endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] ext_addr = '0;
  logic          stb_cpu = 1'b0, stb_ctl = 1'b0, adv = 1'b0, order_sel = 1'b0;
  logic [AW-1:0] cur_addr;
  logic          last_beat;

  int checks = 0;
  int failures = 0;
  logic [AW-1:0] m_base = '0;
  int            m_k = 0;
  logic          m_ord = 1'b0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .BURST_W(2)) i_burst_addr_gen (
    .clk(clk), .rst(rst), .ext_addr(ext_addr), .stb_cpu(stb_cpu),
    .stb_ctl(stb_ctl), .adv(adv), .order_sel(order_sel),
    .cur_addr(cur_addr), .last_beat(last_beat)
  );

  function automatic logic [AW-1:0] exp_addr();
    int s = int'(m_base[1:0]);
    int lo = m_ord ? ((s + m_k) % 4) : (s ^ (m_k % 4));
    return {m_base[AW-1:2], 2'(lo)};
  endfunction

  task automatic check(input string req);
    logic [AW-1:0] ea = exp_addr();
    logic el = ((m_k % 4) == 3);
    checks++;
    if (cur_addr !== ea || last_beat !== el) begin
      failures++;
      $display("FAIL %s: cur_addr=%h last=%b expected cur_addr=%h last=%b",
               req, cur_addr, last_beat, ea, el);
    end
  endtask

  // drive at negedge, let one rising edge pass, update model, check at next negedge
  task automatic cyc(input logic c, input logic t, input logic a,
                     input logic [AW-1:0] ad, input logic o, input string req);
    stb_cpu = c; stb_ctl = t; adv = a; ext_addr = ad; order_sel = o;
    @(posedge clk);
    if (c || t) begin m_base = ad; m_k = 0; m_ord = o; end
    else if (a) m_k = m_k + 1;
    @(negedge clk);
    check(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ext_addr = 8'hFF; stb_cpu = 1'b1; adv = 1'b1;
    repeat (3) @(negedge clk);
    check("R1");
    rst = 1'b0;
    stb_cpu = 1'b0; adv = 1'b0;
    @(negedge clk);
    check("R1");

    // sweep: upper bits x start x order x strobe combination
    for (int hi = 0; hi < 64; hi += 21) begin
      for (int s = 0; s < 4; s++) begin
        for (int o = 0; o < 2; o++) begin
          for (int sc = 1; sc < 4; sc++) begin
            logic [AW-1:0] ad = AW'((hi << 2) | s);
            cyc(sc[0], sc[1], 1'b0, ad, o[0], sc == 3 ? "R3" : "R2");
            for (int b = 0; b < 6; b++) begin
              // advance with order toggled and address noise: R5 R6 R7 R8 R9 R10
              cyc(1'b0, 1'b0, 1'b1, ~ad, ~o[0] ^ b[0],
                  o[0] ? (b == 3 ? "R9_R5" : "R5_R10") : (b == 3 ? "R9_R6" : "R6_R8"));
              if (b == 1) cyc(1'b0, 1'b0, 1'b0, ad ^ 8'h5A, ~o[0], "R4");
            end
          end
        end
      end
    end

    // strobe together with adv: load wins (R3)
    cyc(1'b0, 1'b1, 1'b0, 8'h31, 1'b1, "R2");
    cyc(1'b0, 1'b0, 1'b1, 8'h00, 1'b1, "R5");
    cyc(1'b1, 1'b0, 1'b1, 8'hC6, 1'b0, "R3");
    cyc(1'b0, 1'b1, 1'b1, 8'h47, 1'b1, "R3");
    cyc(1'b1, 1'b1, 1'b1, 8'h9B, 1'b0, "R3");

    // back-to-back loads (R11)
    for (int i = 0; i < 16; i++)
      cyc(i[0], ~i[0], i[1], AW'(i * 37 + 5), i[2], "R11");

    // reset in mid-burst (R1)
    cyc(1'b1, 1'b0, 1'b0, 8'hEE, 1'b1, "R2");
    cyc(1'b0, 1'b0, 1'b1, 8'h00, 1'b1, "R5");
    rst = 1'b1;
    @(posedge clk);
    m_base = '0; m_k = 0; m_ord = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    check("R1");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule